// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block produces the horizontal and vertical timing of a raster display from a single pixel clock. Each axis has a position counter and four programmable boundary values. A two-bit phase register picks which boundary is compared with the counter. Each time the comparison hits, the phase steps on. The four phases, in order, are active display, front porch, sync pulse and back porch. When the back-porch boundary is reached, the counter and the phase return to zero. Blanking and sync levels are decoded from the phases. Sync polarity is set per axis.

A host loads the boundaries, the polarity bits and a raster-line compare value through a one-cycle address/data write port. Horizontal boundaries work in cells of 8 pixels. Vertical boundaries work in pairs of lines. When the raster starts the programmed line, a level interrupt request is raised. It stays up until the host writes to the clear address.

Top module: `raster_timing_gen`

## Requirements
- R1: A write with `hostWe` high is taken at the clock edge. Addresses 0 to 3 hold the horizontal boundaries and 4 to 7 hold the vertical boundaries, each group in the phase order active, front porch, sync, back porch. Address 8 holds the polarity bits (bit 0 horizontal, bit 1 vertical), address 9 holds the interrupt line, and a write to address 10 clears the interrupt. A write to any address from 0 to 8 restarts the raster: after that edge both counters are 0 and both phases are active.
- R2: The horizontal count rises by one per clock. Horizontal phase p ends after the last pixel of cell `boundary[p] >> 3`, cell c being pixels 8c to 8c+7. At the end of the back-porch cell, the count returns to 0 and the phase returns to active, so a line lasts `((hb3 >> 3) + 1) * 8` clocks.
- R3: The three low bits of a horizontal boundary value have no effect on the timing.
- R4: The vertical count rises by one only at the end of each line. Vertical phase p ends after the last line of pair `vboundary[p] >> 1`, so bit 0 of a vertical boundary has no effect. After the back-porch pair, the count returns to 0, so a frame lasts `((vb3 >> 1) + 1) * 2` lines.
- R5: `blank` is 1 whenever either axis is in a phase other than active display, and 0 when both are active.
- R6: A sync output equals its polarity bit, XOR 1 only while its axis is in the sync phase.
- R7: When the horizontal count is 0 and the vertical count equals the interrupt line, `lineIrq` becomes 1 one clock later. It stays 1 across frames until it is cleared.
- R8: A write to address 10 makes `lineIrq` 0 from the next clock, unless a set happens in the same clock, in which case the set wins. This write does not restart the counters.
- R9: While `rst` is high, both counts are 0, `blank`, `hSync`, `vSync` and `lineIrq` are 0, all boundaries and polarity bits are 0, and the interrupt line is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst | input | 1 | synchronous reset, active high |
| hostWe | input | 1 | host write strobe, one write per clock |
| hostAddr | input | 4 | host register index |
| hostData | input | 16 | host write data |
| hCount | output | 11 | horizontal pixel position |
| vCount | output | 10 | vertical line position |
| blank | output | 1 | high outside the active area |
| hSync | output | 1 | horizontal sync, polarity applied |
| vSync | output | 1 | vertical sync, polarity applied |
| lineIrq | output | 1 | raster-line interrupt request level |

## Verification
Two timing sets are loaded and compared cycle by cycle over more than one full frame. The first uses boundaries aligned to cells and pairs, normal polarity, and an interrupt that is cleared in the middle of the run and then sets again on the next frame. The clear separates the level-hold behaviour from a per-frame pulse, and the re-set shows that the clear did not restart the counters. The second set uses boundary values with nonzero low bits, an inverted horizontal sync and a different frame length. A design that compares the full counter, or ignores the polarity bit, fails on the second set and not on the first.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  // strobes issued by the phase control to the datapath
  typedef struct packed {
    logic hStep;
    logic lineEnd;
    logic vStep;
    logic frameEnd;
    logic restart;
  } rtgStrobe_t;

  // comparison results and host events from the datapath
  typedef struct packed {
    logic hMatch;
    logic vMatch;
    logic restartReq;
  } rtgFlags_t;

  localparam int unsigned NUM_BOUNDS = 4;
  localparam int unsigned ADDR_VBASE = 4;
  localparam int unsigned ADDR_POL   = 8;
  localparam int unsigned ADDR_LINE  = 9;
  localparam int unsigned ADDR_CLR   = 10;
endpackage

// File: rtl/rtg_datapath.sv
module rtg_datapath
  import rtg_pkg::*;
#(
  parameter int unsigned HW    = 11,
  parameter int unsigned VW    = 10,
  parameter int unsigned HDROP = 3,
  parameter int unsigned VDROP = 1,
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hostWe,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostData,
  input  rtgStrobe_t    strobe,
  input  logic [1:0]    hPhase,
  input  logic [1:0]    vPhase,
  output rtgFlags_t     flags,
  output logic [HW-1:0] hCnt,
  output logic [VW-1:0] vCnt,
  output logic          hPol,
  output logic          vPol,
  output logic          lineIrq
);
  logic [HW-1:0] hBoundArr [NUM_BOUNDS];
  logic [VW-1:0] vBoundArr [NUM_BOUNDS];
  logic [VW-1:0] irqLine;
  logic [HW-1:0] hSel;
  logic [VW-1:0] vSel;
  logic          irqSet;
  logic          irqClr;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BOUNDS; gi++) begin : gBound
      logic [HW-1:0] hVal;
      logic [VW-1:0] vVal;
      always_ff @(posedge clk) begin
        if (rst) begin
          hVal <= '0;
          vVal <= '0;
        end else if (hostWe) begin
          if (hostAddr == AW'(gi)) hVal <= hostData[HW-1:0];
          if (hostAddr == AW'(gi + ADDR_VBASE)) vVal <= hostData[VW-1:0];
        end
      end
      assign hBoundArr[gi] = hVal;
      assign vBoundArr[gi] = vVal;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hPol    <= 1'b0;
      vPol    <= 1'b0;
      irqLine <= '1;
    end else if (hostWe) begin
      if (hostAddr == AW'(ADDR_POL)) begin
        hPol <= hostData[0];
        vPol <= hostData[1];
      end
      if (hostAddr == AW'(ADDR_LINE)) irqLine <= hostData[VW-1:0];
    end
  end

  assign hSel = hBoundArr[hPhase];
  assign vSel = vBoundArr[vPhase];

  // compare only the cell / pair index, step on the last count of it
  assign flags.hMatch = (hCnt[HW-1:HDROP] == hSel[HW-1:HDROP]) && (&hCnt[HDROP-1:0]);
  assign flags.vMatch = (vCnt[VW-1:VDROP] == vSel[VW-1:VDROP]) && (&vCnt[VDROP-1:0]);
  assign flags.restartReq = hostWe && (hostAddr <= AW'(ADDR_POL));

  always_ff @(posedge clk) begin
    if (rst || strobe.restart || strobe.lineEnd) hCnt <= '0;
    else                                         hCnt <= hCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.restart || strobe.frameEnd) vCnt <= '0;
    else if (strobe.lineEnd)                      vCnt <= vCnt + 1'b1;
  end

  assign irqSet = (hCnt == '0) && (vCnt == irqLine);
  assign irqClr = hostWe && (hostAddr == AW'(ADDR_CLR));

  always_ff @(posedge clk) begin
    if (rst)         lineIrq <= 1'b0;
    else if (irqSet) lineIrq <= 1'b1;
    else if (irqClr) lineIrq <= 1'b0;
  end

  // R2
  line_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.lineEnd |=> (hCnt == '0));
  // R4
  vcnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.lineEnd && !strobe.restart) |=> $stable(vCnt));
  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lineIrq) |-> ($past(hCnt) == '0) && ($past(vCnt) == $past(irqLine)));
  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irqClr && !irqSet) |=> !lineIrq);
endmodule

// File: rtl/rtg_control.sv
module rtg_control
  import rtg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  rtgFlags_t  flags,
  input  logic       hPol,
  input  logic       vPol,
  output rtgStrobe_t strobe,
  output logic [1:0] hPhase,
  output logic [1:0] vPhase,
  output logic       blank,
  output logic       hSync,
  output logic       vSync
);
  localparam logic [1:0] PH_ACTIVE = 2'd0;
  localparam logic [1:0] PH_SYNC   = 2'd2;
  localparam logic [1:0] PH_BACK   = 2'd3;

  always_comb begin
    strobe.restart  = flags.restartReq;
    strobe.hStep    = flags.hMatch;
    strobe.lineEnd  = flags.hMatch && (hPhase == PH_BACK);
    strobe.vStep    = strobe.lineEnd && flags.vMatch;
    strobe.frameEnd = strobe.vStep && (vPhase == PH_BACK);
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.restart) hPhase <= PH_ACTIVE;
    else if (strobe.hStep)     hPhase <= hPhase + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.restart) vPhase <= PH_ACTIVE;
    else if (strobe.vStep)     vPhase <= vPhase + 2'd1;
  end

  assign blank = (hPhase != PH_ACTIVE) || (vPhase != PH_ACTIVE);
  assign hSync = (hPhase == PH_SYNC) ^ hPol;
  assign vSync = (vPhase == PH_SYNC) ^ vPol;

  // R2
  hphase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (flags.hMatch && hPhase == PH_BACK) |=> (hPhase == PH_ACTIVE));
  // R4
  vphase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!flags.hMatch && !flags.restartReq) |=> $stable(vPhase));
  // R1
  restart_phase_chk: assert property (@(posedge clk) disable iff (rst)
    flags.restartReq |=> (hPhase == PH_ACTIVE) && (vPhase == PH_ACTIVE));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int unsigned HW    = 11,
  parameter int unsigned VW    = 10,
  parameter int unsigned HDROP = 3,
  parameter int unsigned VDROP = 1,
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hostWe,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostData,
  output logic [HW-1:0] hCount,
  output logic [VW-1:0] vCount,
  output logic          blank,
  output logic          hSync,
  output logic          vSync,
  output logic          lineIrq
);
  rtgStrobe_t strobe;
  rtgFlags_t  flags;
  logic [1:0] hPhase;
  logic [1:0] vPhase;
  logic       hPol;
  logic       vPol;

  rtg_datapath #(
    .HW(HW), .VW(VW), .HDROP(HDROP), .VDROP(VDROP), .AW(AW), .DW(DW)
  ) uDatapath (
    .clk(clk), .rst(rst), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostData(hostData), .strobe(strobe), .hPhase(hPhase), .vPhase(vPhase),
    .flags(flags), .hCnt(hCount), .vCnt(vCount), .hPol(hPol), .vPol(vPol),
    .lineIrq(lineIrq)
  );

  rtg_control uControl (
    .clk(clk), .rst(rst), .flags(flags), .hPol(hPol), .vPol(vPol),
    .strobe(strobe), .hPhase(hPhase), .vPhase(vPhase),
    .blank(blank), .hSync(hSync), .vSync(vSync)
  );
endmodule

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int   hc;
    int   vc;
    logic bl;
    logic hs;
    logic vs;
    logic irq;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hostWe = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic [15:0] hostData = '0;
  logic [10:0] hCount;
  logic [9:0]  vCount;
  logic        blank, hSync, vSync, lineIrq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  expItem_t expQ[$];

  raster_timing_gen u0 (
    .clk(clk), .rst(rst), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostData(hostData), .hCount(hCount), .vCount(vCount), .blank(blank),
    .hSync(hSync), .vSync(vSync), .lineIrq(lineIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int phaseOf(input int idx, input int b0, input int b1, input int b2);
    if (idx <= b0) return 0;
    if (idx <= b1) return 1;
    if (idx <= b2) return 2;
    return 3;
  endfunction

  task automatic hostWrite(input int addr, input int data);
    @(negedge clk);
    hostWe   = 1'b1;
    hostAddr = addr[3:0];
    hostData = data[15:0];
  endtask

  // monitor: pops one expected item per clock and compares
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check("R2 hCount", int'(hCount), e.hc);
        check("R4 vCount", int'(vCount), e.vc);
        check("R5 blank", int'(blank), int'(e.bl));
        check("R6 hSync", int'(hSync), int'(e.hs));
        check("R6 vSync", int'(vSync), int'(e.vs));
        check("R7 R8 lineIrq", int'(lineIrq), int'(e.irq));
      end
    end
  end

  // driver: reset, program, push expected raster, optional clear at tClr
  task automatic runScenario(input int hb[4], input int vb[4], input int pol,
                             input int irqLine, input int nCycles, input int tClr);
    int hc[4];
    int vcl[4];
    int lineLen, frameLen;
    logic irqE;
    rst = 1'b1;
    hostWe = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 hCount reset", int'(hCount), 0);
    check("R9 vCount reset", int'(vCount), 0);
    check("R9 blank reset", int'(blank), 0);
    check("R9 sync reset", int'({hSync, vSync}), 0);
    check("R9 lineIrq reset", int'(lineIrq), 0);
    rst = 1'b0;
    hostWrite(9, irqLine);
    hostWrite(8, pol);
    for (int i = 0; i < 4; i++) hostWrite(4 + i, vb[i]);
    for (int i = 0; i < 4; i++) hostWrite(i, hb[i]);
    @(negedge clk);
    hostWe = 1'b0;
    // this negedge is t = 0 (R1 restart)
    for (int i = 0; i < 4; i++) begin
      hc[i]  = hb[i] >> 3;   // R3 low bits dropped
      vcl[i] = vb[i] >> 1;
    end
    lineLen  = (hc[3] + 1) * 8;
    frameLen = (vcl[3] + 1) * 2;
    irqE = 1'b0;
    for (int t = 0; t < nCycles; t++) begin
      expItem_t e;
      int hp, vp;
      e.hc = t % lineLen;
      e.vc = (t / lineLen) % frameLen;
      hp = phaseOf(e.hc >> 3, hc[0], hc[1], hc[2]);
      vp = phaseOf(e.vc >> 1, vcl[0], vcl[1], vcl[2]);
      e.bl = (hp != 0) || (vp != 0);
      e.hs = (hp == 2) ^ pol[0];
      e.vs = (vp == 2) ^ pol[1];
      e.irq = irqE;
      expQ.push_back(e);
      if (e.hc == 0 && e.vc == irqLine) irqE = 1'b1;
      else if (t == tClr)               irqE = 1'b0;
    end
    for (int k = 1; k <= nCycles + 2; k++) begin
      @(negedge clk);
      if (k == tClr) begin
        hostWe   = 1'b1;
        hostAddr = 4'd10;
        hostData = '0;
      end else if (k == tClr + 1) begin
        hostWe = 1'b0;
      end
    end
  endtask

  initial begin
    int hbA[4] = '{31, 39, 55, 63};
    int vbA[4] = '{11, 13, 15, 17};
    int hbB[4] = '{45, 50, 71, 81};
    int vbB[4] = '{3, 4, 9, 11};
    // R1 R2 R4 R5 R6 R7 R8: aligned set, clear mid-run, irq re-sets next frame
    runScenario(hbA, vbA, 0, 3, 1500, 1200);
    // R3 R4 R6: unaligned low bits, inverted hsync, no clear
    runScenario(hbB, vbB, 1, 5, 1200, -10);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule